// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Tracker

This block holds the single reservation that load-reserved and store-conditional use on one hart. It decodes each atomic instruction word presented by the datapath, together with the value of the base-address register, and tells the datapath whether a store-conditional may write memory and which status value goes to the destination register. A load-reserved always performs a normal word load; the tracker never blocks it.

After every atomic instruction (load-reserved, store-conditional or any read-modify-write atomic) the tracker applies that instruction's ordering side effect to the reservation. A set release bit drops a matching reservation, and a set acquire bit with release clear takes a new one. The store-conditional decision for an instruction is always made against the reservation as it stood before that instruction, and the side effect becomes visible from the next clock edge. Memory timing and coherence with other harts are handled elsewhere.

Top module: `lrsc_reservation_tracker`

## Requirements
- R1: A synchronous active-low reset clears the reservation, so `resv_valid` reads 0 after the first clock edge with `rst_n` low.
- R2: An instruction is atomic only when `instr_valid` is high, bits [6:0] equal 0101111, bits [14:12] equal 010 and bits [31:27] hold a known code: 00010 load-reserved, 00011 store-conditional, read-modify-write for 00000, 00001, 00100, 01000, 01100, 10000, 10100, 11000, 11100. Bit 26 is acquire, bit 25 is release. Any other word leaves every output inactive and the reservation unchanged.
- R3: A store-conditional whose address is reserved raises `sc_write_en` and drives `rd_status` to 0 in the same cycle.
- R4: A store-conditional with no reservation, or with a different reserved word, keeps `sc_write_en` low and drives `rd_status` to 1.
- R5: Address comparison and the stored reservation use the word address only; bits [1:0] of `rs1_addr` are ignored.
- R6: An atomic instruction with release set whose word matches a valid reservation clears `resv_valid` at the next clock edge.
- R7: An atomic instruction with release set whose word does not match leaves the reservation unchanged.
- R8: An atomic instruction with release clear and acquire set makes the reservation valid for its word at the next edge, replacing any earlier one.
- R9: When acquire and release are both set, release wins and no acquire happens.
- R10: Side effects apply equally to load-reserved, store-conditional and read-modify-write atomics; an atomic with neither bit set leaves the reservation unchanged; `sc_write_en` is never raised for a non-store-conditional.
- R11: The store-conditional outcome uses the reservation held before that instruction's own side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word is presented this cycle |
| instr | input | 32 | Instruction word |
| rs1_addr | input | ADDR_W | Value of the base-address register |
| is_atomic | output | 1 | Word decoded as a legal atomic |
| sc_active | output | 1 | Word decoded as a store-conditional |
| sc_write_en | output | 1 | Store-conditional may write memory |
| rd_status | output | XLEN | Store-conditional status: 0 success, 1 failure, 0 otherwise |
| resv_valid | output | 1 | A reservation is held |
| resv_word | output | ADDR_W-2 | Reserved word address |

## Verification
The bench chases the ordering corner: a store-conditional carrying both ordering bits on a reserved word must succeed and then drop the reservation; a design that updated first would report failure. It also issues releases to a non-matching word (a careless design clears anyway), sets both bits at once (a wrong priority would acquire), and offsets addresses within a word (a full-address compare fails the store). Words with a bad opcode, width field or unknown function code, and idle cycles carrying an atomic word, must leave the reservation untouched.

// File: rtl/lrsc_pkg.sv
// Shared types and encodings for the reservation tracker.
// Assumes a 32-bit instruction word in the standard atomic format.
package lrsc_pkg;

    typedef enum logic [1:0] {
        ATOM_NONE = 2'd0,
        ATOM_LR   = 2'd1,
        ATOM_SC   = 2'd2,
        ATOM_RMW  = 2'd3
    } atom_op_e;

    localparam logic [6:0] ATOMIC_OPCODE = 7'b0101111;
    localparam logic [2:0] WORD_WIDTH_F3 = 3'b010;
    localparam logic [4:0] F5_LR         = 5'b00010;
    localparam logic [4:0] F5_SC         = 5'b00011;

    // Map a function code to its operation class.
    function automatic atom_op_e classify_f5(input logic [4:0] f5);
        case (f5)
            F5_LR:   return ATOM_LR;
            F5_SC:   return ATOM_SC;
            5'b00000, 5'b00001, 5'b00100, 5'b01000, 5'b01100,
            5'b10000, 5'b10100, 5'b11000, 5'b11100: return ATOM_RMW;
            default: return ATOM_NONE;
        endcase
    endfunction

endpackage

// File: rtl/lrsc_decode.sv
// Decodes an instruction word into an atomic class and ordering bits.
// Assumes opcode in [6:0], width field in [14:12], function in [31:27],
// acquire in bit 26 and release in bit 25. Purely combinational.
module lrsc_decode
    import lrsc_pkg::*;
(
    input  logic        valid_i,
    input  logic [31:0] instr_i,
    output atom_op_e    op_o,
    output logic        aq_o,
    output logic        rl_o
);

    logic format_ok;

    // Check fixed fields of the atomic format.
    always_comb begin
        format_ok = valid_i
                 && (instr_i[6:0]   == ATOMIC_OPCODE)
                 && (instr_i[14:12] == WORD_WIDTH_F3);
    end

    // Produce class and ordering bits; nothing leaks out for non-atomics.
    always_comb begin
        op_o = format_ok ? classify_f5(instr_i[31:27]) : ATOM_NONE;
        aq_o = (op_o != ATOM_NONE) && instr_i[26];
        rl_o = (op_o != ATOM_NONE) && instr_i[25];
    end

endmodule

// File: rtl/lrsc_word_match.sv
// Compares the incoming word address with the held reservation.
// Assumes the byte offset has already been stripped by the caller.
module lrsc_word_match #(
    parameter int WORD_W = 30
) (
    input  logic              resv_valid_i,
    input  logic [WORD_W-1:0] resv_word_i,
    input  logic [WORD_W-1:0] req_word_i,
    output logic              hit_o
);

    // Hit only when a reservation exists and the words agree.
    always_comb begin
        hit_o = resv_valid_i && (resv_word_i == req_word_i);
    end

endmodule

// File: rtl/lrsc_resv_reg.sv
// Holds the single reservation and applies ordering side effects.
// Assumes op/aq/rl come from the decoder and hit from the word comparator
// evaluated on the pre-update state. Release has priority over acquire.
module lrsc_resv_reg
    import lrsc_pkg::*;
#(
    parameter int WORD_W = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  atom_op_e          op_i,
    input  logic              aq_i,
    input  logic              rl_i,
    input  logic              hit_i,
    input  logic [WORD_W-1:0] req_word_i,
    output logic              valid_o,
    output logic [WORD_W-1:0] word_o
);

    logic is_atom;
    logic do_release;
    logic do_acquire;

    // Choose the side effect for this cycle.
    always_comb begin
        is_atom    = (op_i != ATOM_NONE);
        do_release = is_atom && rl_i && hit_i;
        do_acquire = is_atom && !rl_i && aq_i;
    end

    // Update the reservation at the clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            word_o  <= '0;
        end else if (do_release) begin
            valid_o <= 1'b0;
        end else if (do_acquire) begin
            valid_o <= 1'b1;
            word_o  <= req_word_i;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !valid_o);

    a_r6_release_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (is_atom && rl_i && hit_i) |=> !valid_o);

    a_r7_release_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (is_atom && rl_i && !hit_i) |=> ($stable(valid_o) && $stable(word_o)));

    a_r8_acquire: assert property (@(posedge clk) disable iff (!rst_n)
        (is_atom && !rl_i && aq_i) |=> (valid_o && word_o == $past(req_word_i)));

    a_r2_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == ATOM_NONE) |=> ($stable(valid_o) && $stable(word_o)));

endmodule

// File: rtl/lrsc_reservation_tracker.sv
// Top of the reservation tracker: decode, compare, decide, update.
// Assumes a single hart; the store-conditional decision is combinational
// on the pre-update reservation, side effects land at the next edge.
module lrsc_reservation_tracker
    import lrsc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      instr_valid,
    input  logic [31:0]               instr,
    input  logic [ADDR_W-1:0]         rs1_addr,
    output logic                      is_atomic,
    output logic                      sc_active,
    output logic                      sc_write_en,
    output logic [XLEN-1:0]           rd_status,
    output logic                      resv_valid,
    output logic [ADDR_W-$clog2(WORD_BYTES)-1:0] resv_word
);

    localparam int OFF_W  = $clog2(WORD_BYTES);
    localparam int WORD_W = ADDR_W - OFF_W;

    atom_op_e          op;
    logic              aq, rl, hit;
    logic [WORD_W-1:0] req_word;

    // Strip the byte offset from the request address.
    always_comb begin
        req_word = rs1_addr[ADDR_W-1:OFF_W];
    end

    lrsc_decode u_decode (
        .valid_i (instr_valid),
        .instr_i (instr),
        .op_o    (op),
        .aq_o    (aq),
        .rl_o    (rl)
    );

    lrsc_word_match #(.WORD_W(WORD_W)) u_match (
        .resv_valid_i (resv_valid),
        .resv_word_i  (resv_word),
        .req_word_i   (req_word),
        .hit_o        (hit)
    );

    lrsc_resv_reg #(.WORD_W(WORD_W)) u_resv (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op),
        .aq_i       (aq),
        .rl_i       (rl),
        .hit_i      (hit),
        .req_word_i (req_word),
        .valid_o    (resv_valid),
        .word_o     (resv_word)
    );

    // Drive the datapath decision from the pre-update reservation.
    always_comb begin
        is_atomic   = (op != ATOM_NONE);
        sc_active   = (op == ATOM_SC);
        sc_write_en = sc_active && hit;
        rd_status   = '0;
        if (sc_active && !hit) rd_status = XLEN'(1);
    end

    a_r3_write_needs_resv: assert property (@(posedge clk) disable iff (!rst_n)
        sc_write_en |-> (resv_valid && resv_word == rs1_addr[ADDR_W-1:OFF_W]));

    a_r10_write_only_sc: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_active |-> (!sc_write_en && rd_status == '0));

    a_r4_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        sc_active |-> (sc_write_en != rd_status[0]));

endmodule

// File: tb/test_lrsc_reservation_tracker.sv
module test_lrsc_reservation_tracker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic [31:0] instr;
    logic [31:0] rs1_addr;
    logic        is_atomic, sc_active, sc_write_en, resv_valid;
    logic [31:0] rd_status;
    logic [29:0] resv_word;

    int n_cmp  = 0;
    int n_bad  = 0;
    int cycles = 0;

    // reference state
    bit          m_valid;
    bit [29:0]   m_word;

    always #5 clk = ~clk;

    lrsc_reservation_tracker i_lrsc_reservation_tracker (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .rs1_addr(rs1_addr), .is_atomic(is_atomic), .sc_active(sc_active),
        .sc_write_en(sc_write_en), .rd_status(rd_status),
        .resv_valid(resv_valid), .resv_word(resv_word)
    );

    function automatic logic [31:0] enc(input bit [4:0] f5, input bit aq, input bit rl);
        return {f5, aq, rl, 5'd7, 5'd3, 3'b010, 5'd9, 7'b0101111};
    endfunction

    // class: 0 none, 1 LR, 2 SC, 3 RMW
    function automatic int kind_of(input bit v, input bit [31:0] w);
        if (!v || w[6:0] != 7'b0101111 || w[14:12] != 3'b010) return 0;
        if (w[31:27] == 5'b00010) return 1;
        if (w[31:27] == 5'b00011) return 2;
        if (w[31:27] inside {5'b00000, 5'b00001, 5'b00100, 5'b01000, 5'b01100,
                             5'b10000, 5'b10100, 5'b11000, 5'b11100}) return 3;
        return 0;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Present one word, compare against the model, then clock it in.
    task automatic step(input string tag, input bit v, input logic [31:0] w,
                        input logic [31:0] a);
        int  k;
        bit  hit, aq, rl;
        instr_valid = v; instr = w; rs1_addr = a;
        #1;
        k   = kind_of(v, w);
        hit = m_valid && (m_word == a[31:2]);
        aq  = w[26]; rl = w[25];
        check(tag, "is_atomic",   is_atomic,   k != 0);
        check(tag, "sc_active",   sc_active,   k == 2);
        check(tag, "sc_write_en", sc_write_en, (k == 2) && hit);
        check(tag, "rd_status",   rd_status,   ((k == 2) && !hit) ? 32'd1 : 32'd0);
        check(tag, "resv_valid",  resv_valid,  m_valid);
        if (m_valid) check(tag, "resv_word", resv_word, m_word);
        @(posedge clk);
        if (k != 0) begin
            if (rl) begin
                if (hit) m_valid = 0;
            end else if (aq) begin
                m_valid = 1; m_word = a[31:2];
            end
        end
        @(negedge clk);
    endtask

    localparam logic [31:0] A = 32'h0000_1000;
    localparam logic [31:0] B = 32'h0000_2004;
    localparam logic [31:0] C = 32'h8000_0ff8;

    initial begin
        rst_n = 1'b0; instr_valid = 0; instr = '0; rs1_addr = '0;
        m_valid = 0; m_word = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "resv_valid after reset", resv_valid, 1'b0);
        rst_n = 1'b1;

        step("R4", 1, enc(5'b00011, 0, 0), A);           // SC, nothing held
        step("R8", 1, enc(5'b00010, 1, 0), A);           // LR acquire
        step("R3", 1, enc(5'b00011, 0, 0), A);           // SC hit
        step("R5", 1, enc(5'b00011, 0, 0), A + 3);       // offset ignored
        step("R4", 1, enc(5'b00011, 0, 0), B);           // other word
        step("R7", 1, enc(5'b00010, 0, 1), B);           // release miss
        step("R7", 1, enc(5'b00011, 0, 0), A);           // still held
        step("R6", 1, enc(5'b00010, 0, 1), A + 2);       // release hit
        step("R6", 1, enc(5'b00011, 0, 0), A);           // now fails
        step("R10", 1, enc(5'b00001, 1, 0), B);          // RMW acquire
        step("R8", 1, enc(5'b00010, 1, 0), C);           // replace
        step("R8", 1, enc(5'b00011, 0, 0), B);           // old word gone
        step("R10", 1, enc(5'b01000, 0, 0), A);          // no bits: unchanged
        step("R11", 1, enc(5'b00011, 1, 1), C);          // both bits: succeeds
        step("R9", 1, enc(5'b00011, 0, 0), C);           // released, no acquire
        step("R9", 1, enc(5'b10000, 1, 1), A);           // both, nothing held
        step("R9", 1, enc(5'b00011, 0, 0), A);
        step("R8", 1, enc(5'b11100, 1, 0), A);
        step("R2", 1, enc(5'b00010, 0, 1) ^ 32'h1, A);   // bad opcode
        step("R2", 1, enc(5'b00010, 0, 1) ^ 32'h1000, A);// bad width
        step("R2", 1, enc(5'b00101, 0, 1), A);           // unknown code
        step("R2", 0, enc(5'b00010, 0, 1), A);           // not valid
        step("R2", 1, enc(5'b00011, 0, 0), A);           // still held
        step("R11", 1, enc(5'b00011, 0, 1), A);          // SC releases after success
        step("R11", 1, enc(5'b00011, 0, 0), A);

        for (int i = 0; i < 400; i++) begin
            bit [4:0]  f5;
            bit [31:0] a;
            case ($urandom_range(0, 4))
                0: f5 = 5'b00010;
                1: f5 = 5'b00011;
                2: f5 = 5'b00100;
                3: f5 = 5'b01100;
                default: f5 = 5'(($urandom_range(0, 31)));
            endcase
            a = {28'h0000_100, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
            step("R10", ($urandom_range(0, 7) != 0),
                 enc(f5, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1))), a);
        end

        rst_n = 1'b0;
        step("R1", 1, enc(5'b00010, 1, 0), A);
        m_valid = 0;
        check("R1", "resv_valid after late reset", resv_valid, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule